// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block follows the fault-confinement standing of a CAN node. A protocol engine next to it sends single-cycle strobes: one for each transmit error, receive error, successful transmission and successful reception. It also sends a bit tick with the sampled bus level. From these the block keeps a transmit error count and a receive error count. It moves between three named states: ERROR_ACTIVE, ERROR_PASSIVE and BUS_OFF. The state drives status flags, a warning flag, masked interrupt-pending bits, a transmit-suspend output and a bus-isolate output. Both counts can be read at the ports.

The state register samples the counts one cycle after they change. The transitions are as follows:
- ACTIVE_TO_PASSIVE: either count above 127.
- PASSIVE_TO_ACTIVE: both counts below 127.
- ANY_TO_BUSOFF: the transmit count above 255. This check takes priority.
- BUSOFF_TO_ACTIVE: 128 complete runs of 11 consecutive recessive bits, or reset.

While the block is in BUS_OFF, error and success strobes leave the counts unchanged. Recovery clears both counts.

Top module: `can_fault_confine`

## Requirements
- R1: After reset the state is ERROR_ACTIVE, both counts are 0, warning, transmit-suspend and bus-isolate are low, and exactly one state flag is high.
- R2: A transmit error adds 8 to the transmit count and a receive error adds 1 to the receive count. A success strobe subtracts 1 from its own count, which never goes below 0. When an error and a success for the same count arrive in one cycle, the error wins.
- R3: The receive count saturates at 511 and does not wrap.
- R4: ACTIVE_TO_PASSIVE happens one cycle after either count becomes greater than 127.
- R5: In ERROR_PASSIVE the state holds while either count is 127 or more. PASSIVE_TO_ACTIVE happens once both counts are below 127.
- R6: ANY_TO_BUSOFF happens once the transmit count exceeds 255. In BUS_OFF all error and success strobes leave both counts unchanged.
- R7: BUSOFF_TO_ACTIVE happens on the bit tick that completes the 128th run of 11 consecutive recessive bits, and both counts clear at that edge. Any dominant bit restarts the current run.
- R8: The warning flag is high while either count exceeds 96. Warning alone does not move the node out of ERROR_ACTIVE.
- R9: irq_pending[i] = flag[i] AND irq_mask[i], with bit 0 active, bit 1 passive, bit 2 bus-off and bit 3 warning.
- R10: In ERROR_PASSIVE a transmit error or transmit success raises tx_suspend. tx_suspend stays high for the next 8 bit ticks and then drops.
- R11: bus_isolate is high exactly while the state is BUS_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the controller reset |
| tx_err_evt | input | 1 | Transmit error strobe |
| rx_err_evt | input | 1 | Receive error strobe |
| tx_ok_evt | input | 1 | Successful transmission strobe |
| rx_ok_evt | input | 1 | Successful reception strobe |
| bit_tick | input | 1 | One pulse per sampled bus bit |
| bit_recessive | input | 1 | Sampled level at bit_tick, 1 = recessive |
| irq_mask | input | 4 | Interrupt mask, bit order as in R9 |
| tec | output | 9 | Transmit error count |
| rec | output | 9 | Receive error count |
| st_active | output | 1 | State is ERROR_ACTIVE |
| st_passive | output | 1 | State is ERROR_PASSIVE |
| st_busoff | output | 1 | State is BUS_OFF |
| warn | output | 1 | Either count above 96 |
| irq_pending | output | 4 | Masked pending interrupts |
| tx_suspend | output | 1 | Transmission suspended after sending while passive |
| bus_isolate | output | 1 | Node isolated from the bus |

## Verification
A short vector table applies strobe combinations one at a time and checks the counts after each. It covers single errors, paired successes, a success on an empty count, and an error with a success on the same count in one cycle, so step sizes, the zero floor and error priority can each be told apart. Directed ramps then drive the transmit count through 96, 127, 128 and 255. These separate the warning threshold from the passive threshold and show the hysteresis at exactly 127. A recessive stream broken by one dominant bit, checked one bit before and at the 1408th recessive bit, shows whether a dominant bit restarts the run. A long run of receive errors shows saturation against wrap.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    localparam int IRQ_ACTIVE  = 0;
    localparam int IRQ_PASSIVE = 1;
    localparam int IRQ_BUSOFF  = 2;
    localparam int IRQ_WARN    = 3;
    localparam int IRQ_W       = 4;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         freeze,
    input  logic         err,
    input  logic         ok,
    output logic [W-1:0] cnt
);
    localparam logic [W:0]   STEP_X = (W+1)'(STEP);
    localparam logic [W-1:0] TOP    = {W{1'b1}};

    logic [W:0] sum;
    assign sum = {1'b0, cnt} + STEP_X;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (freeze)
            cnt <= cnt;
        else if (err)
            cnt <= sum[W] ? TOP : sum[W-1:0];
        else if (ok && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // R3: a full count stays full under further errors
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && err && !freeze && !clr) |=> cnt == TOP);
    // R2: success on an empty count does not underflow
    p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && ok && !err && !freeze && !clr) |=> cnt == '0);
    // R6: frozen count holds
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic bit_recessive,
    output logic done
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam int NUM_W = $clog2(RUN_COUNT);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [NUM_W-1:0] NUM_LAST = NUM_W'(RUN_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [NUM_W-1:0] num_q;
    logic             run_end;

    assign run_end = enable && bit_tick && bit_recessive && run_q == RUN_LAST;
    assign done    = run_end && num_q == NUM_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            num_q <= '0;
        end else if (!enable) begin
            run_q <= '0;
            num_q <= '0;
        end else if (bit_tick) begin
            if (!bit_recessive) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                num_q <= num_q + 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R7: a dominant bit restarts the current run
    p_dominant_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_tick && !bit_recessive) |=> run_q == '0);
    // R7: completed-run count only advances on a recessive tick
    p_runs_need_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(bit_tick && bit_recessive)) |=> $stable(num_q));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int CNT_W         = 9,
    parameter int TX_STEP       = 8,
    parameter int RX_STEP       = 1,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int RUN_LEN       = 11,
    parameter int RUN_COUNT     = 128,
    parameter int SUSPEND_LEN   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_evt,
    input  logic             rx_err_evt,
    input  logic             tx_ok_evt,
    input  logic             rx_ok_evt,
    input  logic             bit_tick,
    input  logic             bit_recessive,
    input  logic [3:0]       irq_mask,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             st_active,
    output logic             st_passive,
    output logic             st_busoff,
    output logic             warn,
    output logic [3:0]       irq_pending,
    output logic             tx_suspend,
    output logic             bus_isolate
);
    localparam logic [CNT_W-1:0] LIM_WARN = CNT_W'(WARN_LIMIT);
    localparam logic [CNT_W-1:0] LIM_PAS  = CNT_W'(PASSIVE_LIMIT);
    localparam logic [CNT_W-1:0] LIM_BOFF = CNT_W'(BUSOFF_LIMIT);
    localparam int               SUS_W    = $clog2(SUSPEND_LEN + 1);
    localparam logic [SUS_W-1:0] SUS_LOAD = SUS_W'(SUSPEND_LEN);

    fc_state_e        state_q, state_d;
    logic             recovered;
    logic             frozen;
    logic [SUS_W-1:0] sus_q;
    logic [IRQ_W-1:0] flags;

    assign frozen = (state_q == FC_BUSOFF);

    fc_err_counter #(.W(CNT_W), .STEP(TX_STEP)) u_tec (
        .clk(clk), .rst_n(rst_n), .clr(recovered), .freeze(frozen),
        .err(tx_err_evt), .ok(tx_ok_evt), .cnt(tec)
    );

    fc_err_counter #(.W(CNT_W), .STEP(RX_STEP)) u_rec (
        .clk(clk), .rst_n(rst_n), .clr(recovered), .freeze(frozen),
        .err(rx_err_evt), .ok(rx_ok_evt), .cnt(rec)
    );

    fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
        .clk(clk), .rst_n(rst_n), .enable(frozen), .bit_tick(bit_tick),
        .bit_recessive(bit_recessive), .done(recovered)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (tec > LIM_BOFF)                        state_d = FC_BUSOFF;
                else if (tec > LIM_PAS || rec > LIM_PAS)   state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (tec > LIM_BOFF)                        state_d = FC_BUSOFF;
                else if (tec < LIM_PAS && rec < LIM_PAS)   state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recovered)                             state_d = FC_ACTIVE;
            end
            default:                                       state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_ACTIVE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sus_q <= '0;
        else if (state_q != FC_PASSIVE)
            sus_q <= '0;
        else if (tx_err_evt || tx_ok_evt)
            sus_q <= SUS_LOAD;
        else if (bit_tick && sus_q != '0)
            sus_q <= sus_q - 1'b1;
    end

    always_comb begin
        st_active   = (state_q == FC_ACTIVE);
        st_passive  = (state_q == FC_PASSIVE);
        st_busoff   = (state_q == FC_BUSOFF);
        bus_isolate = st_busoff;
        warn        = (tec > LIM_WARN) || (rec > LIM_WARN);
        tx_suspend  = st_passive && (sus_q != '0);
        flags                = '0;
        flags[IRQ_ACTIVE]    = st_active;
        flags[IRQ_PASSIVE]   = st_passive;
        flags[IRQ_BUSOFF]    = st_busoff;
        flags[IRQ_WARN]      = warn;
        irq_pending          = flags & irq_mask;
    end

    // R1: exactly one state flag at a time
    p_one_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_active, st_passive, st_busoff}) == 1);
    // R4: active node with a count above the passive limit turns passive
    p_enter_passive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && tec <= LIM_BOFF && (tec > LIM_PAS || rec > LIM_PAS)) |=> st_passive);
    // R5: passive holds while either count is at or above the limit
    p_hold_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_passive && tec <= LIM_BOFF && (tec >= LIM_PAS || rec >= LIM_PAS)) |=> st_passive);
    // R6: transmit count past the bus-off limit isolates the node
    p_enter_busoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_busoff && tec > LIM_BOFF) |=> bus_isolate);
    // R8: warning alone never moves the node out of active
    p_warn_keeps_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && tec <= LIM_PAS && rec <= LIM_PAS) |=> st_active);
    // R10: suspend only counts down on bit ticks
    p_suspend_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_passive && $past(st_passive) && $fell(tx_suspend)) |-> $past(bit_tick));
endmodule

// File: tb/can_fault_confine_tb.sv
module can_fault_confine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err_evt = 1'b0, rx_err_evt = 1'b0, tx_ok_evt = 1'b0, rx_ok_evt = 1'b0;
    logic       bit_tick = 1'b0, bit_recessive = 1'b1;
    logic [3:0] irq_mask = 4'b1111;
    logic [8:0] tec, rec;
    logic       st_active, st_passive, st_busoff, warn, tx_suspend, bus_isolate;
    logic [3:0] irq_pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    can_fault_confine u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
        .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt),
        .bit_tick(bit_tick), .bit_recessive(bit_recessive),
        .irq_mask(irq_mask), .tec(tec), .rec(rec),
        .st_active(st_active), .st_passive(st_passive), .st_busoff(st_busoff),
        .warn(warn), .irq_pending(irq_pending),
        .tx_suspend(tx_suspend), .bus_isolate(bus_isolate)
    );

    // {tx_err, rx_err, tx_ok, rx_ok, exp_tec[8:0], exp_rec[8:0], exp_state[1:0]}
    // state code: 0 active, 1 passive, 2 bus-off
    localparam int NVEC = 7;
    localparam logic [23:0] VEC [NVEC] = '{
        {4'b1000, 9'd8,  9'd0, 2'd0},
        {4'b0100, 9'd8,  9'd1, 2'd0},
        {4'b0011, 9'd7,  9'd0, 2'd0},
        {4'b0001, 9'd7,  9'd0, 2'd0},
        {4'b1010, 9'd15, 9'd0, 2'd0},
        {4'b0110, 9'd14, 9'd1, 2'd0},
        {4'b0101, 9'd14, 9'd2, 2'd0}
    };

    function automatic int st_code();
        return st_busoff ? 2 : (st_passive ? 1 : 0);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ev(input logic te, input logic re, input logic to, input logic ro);
        @(negedge clk);
        tx_err_evt = te; rx_err_evt = re; tx_ok_evt = to; rx_ok_evt = ro;
        @(negedge clk);
        tx_err_evt = 0; rx_err_evt = 0; tx_ok_evt = 0; rx_ok_evt = 0;
    endtask

    task automatic bits(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1; bit_recessive = lvl;
            @(negedge clk);
            bit_tick = 1'b0; bit_recessive = 1'b1;
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 state", st_code(), 0);
        chk("R1 tec", int'(tec), 0);
        chk("R1 rec", int'(rec), 0);
        chk("R1 warn/suspend/isolate", int'({warn, tx_suspend, bus_isolate}), 0);
        chk("R9 irq after reset", int'(irq_pending), 1);

        // R2 vector table
        for (int v = 0; v < NVEC; v++) begin
            ev(VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20]);
            settle();
            chk("R2 tec", int'(tec), int'(VEC[v][19:11]));
            chk("R2 rec", int'(rec), int'(VEC[v][10:2]));
            chk("R2 state", st_code(), int'(VEC[v][1:0]));
        end

        // R8 warning at 102, still active
        for (int i = 0; i < 11; i++) ev(1, 0, 0, 0);
        settle();
        chk("R8 tec", int'(tec), 102);
        chk("R8 warn", int'(warn), 1);
        chk("R8 state", st_code(), 0);
        chk("R9 irq warn+active", int'(irq_pending), 9);

        // R4: 126 stays active, 134 goes passive
        for (int i = 0; i < 3; i++) ev(1, 0, 0, 0);
        settle();
        chk("R4 at 126", st_code(), 0);
        ev(1, 0, 0, 0);
        settle();
        chk("R4 tec", int'(tec), 134);
        chk("R4 passive", st_code(), 1);
        irq_mask = 4'b0010;
        settle();
        chk("R9 masked irq", int'(irq_pending), 2);
        irq_mask = 4'b1111;
        chk("R10 no suspend yet", int'(tx_suspend), 0);

        // R10 suspend after a transmission while passive
        ev(0, 0, 1, 0);
        settle();
        chk("R10 suspend raised", int'(tx_suspend), 1);
        bits(7, 1'b1);
        settle();
        chk("R10 suspend after 7 ticks", int'(tx_suspend), 1);
        bits(1, 1'b1);
        settle();
        chk("R10 suspend after 8 ticks", int'(tx_suspend), 0);

        // R5 hysteresis at 127
        for (int i = 0; i < 6; i++) ev(0, 0, 1, 0);
        settle();
        chk("R5 tec 127", int'(tec), 127);
        chk("R5 hold passive", st_code(), 1);
        ev(0, 0, 1, 0);
        settle();
        chk("R5 back to active", st_code(), 0);
        chk("R10 no suspend when active", int'(tx_suspend), 0);

        // R6 bus-off
        for (int i = 0; i < 16; i++) ev(1, 0, 0, 0);
        settle();
        chk("R6 tec 254", int'(tec), 254);
        chk("R6 still passive", st_code(), 1);
        ev(1, 0, 0, 0);
        settle();
        chk("R6 busoff", st_code(), 2);
        chk("R11 isolate", int'(bus_isolate), 1);
        chk("R10 no suspend in busoff", int'(tx_suspend), 0);
        chk("R9 irq busoff+warn", int'(irq_pending), 12);
        ev(1, 1, 0, 0);
        ev(0, 0, 1, 1);
        settle();
        chk("R6 tec frozen", int'(tec), 262);
        chk("R6 rec frozen", int'(rec), 2);

        // R7 recovery with a broken run
        bits(10, 1'b1);
        bits(1, 1'b0);
        bits(1407, 1'b1);
        settle();
        chk("R7 one bit short", st_code(), 2);
        bits(1, 1'b1);
        settle();
        chk("R7 recovered", st_code(), 0);
        chk("R7 tec cleared", int'(tec), 0);
        chk("R7 rec cleared", int'(rec), 0);
        chk("R11 isolate off", int'(bus_isolate), 0);

        // R3 receive saturation
        for (int i = 0; i < 515; i++) ev(0, 1, 0, 0);
        settle();
        chk("R3 rec saturated", int'(rec), 511);
        chk("R3 tec untouched", int'(tec), 0);
        chk("R4 rec drives passive", st_code(), 1);

        // R1 reset from passive
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        settle();
        chk("R1 rec after reset", int'(rec), 0);
        chk("R1 state after reset", st_code(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule